// File: doc/BRIEF.md
# Two-Stage Guarded Watchdog Timer

This block is a watchdog with two chained countdown stages. Once enabled, it loads a first preload value and counts it down on a prescaled tick. When the first stage runs out, the block can pulse an interrupt. It then loads a second preload value and counts again. When the second stage runs out, the block pulses a reset request and sets a flag that stays set until software clears it.

Software sees a small register file of three words: two preloads and a kick/status word. Every write that changes state must come straight after a two-key unlock pattern written to the kick word. A reload through the kick word restarts the countdown from the first preload. Three level inputs control the block: the enable, the tick rate and the interrupt mask.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, both preloads read 0xFFFFF, the kick word reads 0, and `irq` and `rst_req` are low.
- R2: A write to address 0 (first preload), 1 (second preload) or 2 (kick word) takes effect only when it directly follows a write of 0x80 and then a write of 0x86 to address 2. Only that one write is accepted, and the guard then closes again.
- R3: Any write that breaks the key pattern returns the guard to its locked state: a wrong value, a wrong address or a key out of order. A guarded write made without the pattern leaves the register unchanged.
- R4: The countdown tick comes every 32 clocks when `cfg_fast_tick` is 1 and every 32768 clocks when it is 0.
- R5: `irq` is high for one cycle, exactly first-preload ticks after the countdown starts, unless `cfg_irq_off` is 1, in which case it stays low.
- R6: `rst_req` is high for one cycle, exactly first-preload plus second-preload ticks after the countdown starts. The countdown then begins again from the first preload.
- R7: Expiry of the second stage sets the timeout flag, readable as bit 9 of the kick word. Only an unlocked kick write with bit 9 set clears it, or power-on reset. Disabling the block does not clear it.
- R8: An unlocked kick write with bit 8 set restarts the prescaler and the countdown from the first preload.
- R9: While `cfg_enable` is low nothing counts and no output pulses. When the block is enabled again, it starts afresh from the first preload.
- R10: A preload of zero counts as one tick.
- R11: `reg_rdata` is registered. It shows the word at the address presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_addr | input | 2 | Register address: 0 first preload, 1 second preload, 2 kick/status |
| reg_wdata | input | DW | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | DW | Registered read data |
| cfg_enable | input | 1 | Runs the watchdog when high |
| cfg_fast_tick | input | 1 | 1 selects the divide-by-32 tick, 0 the divide-by-32768 tick |
| cfg_irq_off | input | 1 | Suppresses the first-stage interrupt |
| irq | output | 1 | One-cycle first-stage expiry pulse |
| rst_req | output | 1 | One-cycle second-stage expiry pulse |

## Verification
The assertions assume that the divide ratios are at least two and that the data word is wide enough to hold bit 9. They also assume that a write strobe lasts exactly one cycle per access. The one-shot unlock window depends on that last point. The bench drives every write as a single-cycle strobe and changes the configuration inputs only at falling edges. It changes the tick rate only while the block is disabled, so no count is ever cut short by a rate switch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    A_PRE1 = 2'd0,
    A_PRE2 = 2'd1,
    A_KICK = 2'd2,
    A_NONE = 2'd3
  } waddr_e;

  typedef enum logic [1:0] {
    U_IDLE = 2'd0,
    U_HALF = 2'd1,
    U_OPEN = 2'd2
  } ulk_e;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;
  localparam int KICK_RELOAD_BIT = 8;
  localparam int KICK_FLAG_BIT   = 9;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          grant
);
  ulk_e st;
  logic is_kick;

  assign is_kick = (wr_addr == A_KICK);
  assign grant   = wr_en && (st == U_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= U_IDLE;
    end else if (wr_en) begin
      case (st)
        U_IDLE:  st <= (is_kick && wr_data == DW'(KEY_FIRST))  ? U_HALF : U_IDLE;
        U_HALF:  st <= (is_kick && wr_data == DW'(KEY_SECOND)) ? U_OPEN : U_IDLE;
        default: st <= U_IDLE;
      endcase
    end
  end

  // R2: the window admits a single write
  a_r2_one_shot: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == U_OPEN) |=> (st != U_OPEN));
  // R3: the locked state can never jump straight to open
  a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
    (st == U_IDLE) |=> (st != U_OPEN));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          wrap;

  assign lim  = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
  assign wrap = (cnt >= lim);
  assign tick = run && !restart && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (wrap)              cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end

  // R4: ticks are spaced apart, never back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          restart,
  input  logic          irq_off,
  input  logic [DW-1:0] pre1,
  input  logic [DW-1:0] pre2,
  output logic          irq,
  output logic          rst_req
);
  logic          second;
  logic [DW-1:0] cnt;

  function automatic logic [DW-1:0] ld(input logic [DW-1:0] v);
    return (v == '0) ? DW'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      second  <= 1'b0;
      cnt     <= DW'(1);
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      if (!run || restart) begin
        second <= 1'b0;
        cnt    <= ld(pre1);
      end else if (tick) begin
        if (cnt <= DW'(1)) begin
          if (!second) begin
            second <= 1'b1;
            cnt    <= ld(pre2);
            irq    <= !irq_off;
          end else begin
            second  <= 1'b0;
            cnt     <= ld(pre1);
            rst_req <= 1'b1;
          end
        end else begin
          cnt <= cnt - DW'(1);
        end
      end
    end
  end

  // R5: interrupt is a single-cycle pulse
  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R5: a masked interrupt never appears
  a_r5_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> !$past(irq_off));
  // R6: reset request is a single-cycle pulse coming out of stage two
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r6_req_from_stage2: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(second));
  // R10: the remaining count never sits at zero
  a_r10_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int          DW       = 20,
  parameter int          DIV_FAST = 32,
  parameter int          DIV_SLOW = 32768,
  parameter int unsigned PRE_RST  = 'hFFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic          cfg_enable,
  input  logic          cfg_fast_tick,
  input  logic          cfg_irq_off,
  output logic          irq,
  output logic          rst_req
);
  logic          grant;
  logic          tick;
  logic          reload;
  logic          flag_clr;
  logic          flag;
  logic [DW-1:0] pre1;
  logic [DW-1:0] pre2;
  logic [DW-1:0] kick_view;

  wdog_unlock #(.DW(DW)) u_unlock (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .grant(grant)
  );

  assign reload   = grant && (reg_addr == A_KICK) && reg_wdata[KICK_RELOAD_BIT];
  assign flag_clr = grant && (reg_addr == A_KICK) && reg_wdata[KICK_FLAG_BIT];

  wdog_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
    .clk(clk), .rst(rst), .run(cfg_enable), .fast(cfg_fast_tick),
    .restart(reload), .tick(tick)
  );

  wdog_countdown #(.DW(DW)) u_count (
    .clk(clk), .rst(rst), .run(cfg_enable), .tick(tick), .restart(reload),
    .irq_off(cfg_irq_off), .pre1(pre1), .pre2(pre2),
    .irq(irq), .rst_req(rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pre1 <= DW'(PRE_RST);
      pre2 <= DW'(PRE_RST);
      flag <= 1'b0;
    end else begin
      if (grant && reg_addr == A_PRE1) pre1 <= reg_wdata;
      if (grant && reg_addr == A_PRE2) pre2 <= reg_wdata;
      if (rst_req)       flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  always_comb begin
    kick_view = '0;
    kick_view[KICK_FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_PRE1:  reg_rdata <= pre1;
        A_PRE2:  reg_rdata <= pre2;
        A_KICK:  reg_rdata <= kick_view;
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R3: a guarded preload write without the key pattern changes nothing
  a_r3_pre1_guarded: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_PRE1 && !grant) |=> $stable(pre1));
  // R7: the flag follows stage-two expiry and holds until an unlocked clear
  a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> flag);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int DW = 20;
  localparam int FAST = 32;
  localparam int SLOW = 32768;
  localparam int NSTEP = 13;
  // {addr, write data, expected first preload afterwards}
  localparam logic [41:0] STEPS [NSTEP] = '{
    {2'd0, 20'h00005, 20'hFFFFF},
    {2'd2, 20'h00086, 20'hFFFFF},
    {2'd2, 20'h00080, 20'hFFFFF},
    {2'd0, 20'h00007, 20'hFFFFF},
    {2'd2, 20'h00086, 20'hFFFFF},
    {2'd2, 20'h00080, 20'hFFFFF},
    {2'd2, 20'h00086, 20'hFFFFF},
    {2'd0, 20'h0000A, 20'h0000A},
    {2'd0, 20'h0000B, 20'h0000A},
    {2'd2, 20'h00080, 20'h0000A},
    {2'd2, 20'h00080, 20'h0000A},
    {2'd2, 20'h00086, 20'h0000A},
    {2'd0, 20'h0000C, 20'h0000A}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic          cfg_enable = 1'b0;
  logic          cfg_fast_tick = 1'b1;
  logic          cfg_irq_off = 1'b0;
  logic          irq;
  logic          rst_req;

  int total = 0;
  int bad = 0;
  int irq_hits = 0;
  int rst_hits = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  wdog_two_stage u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .cfg_enable(cfg_enable),
    .cfg_fast_tick(cfg_fast_tick), .cfg_irq_off(cfg_irq_off),
    .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) begin
    if (!rst) begin
      irq_hits = irq_hits + int'(irq);
      rst_hits = rst_hits + int'(rst_req);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic uwr(input logic [1:0] a, input logic [DW-1:0] d);
    wr(2'd2, 20'h80); wr(2'd2, 20'h86); wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = int'(reg_rdata);
  endtask

  // runs n edges from now, reports the first edge showing irq / rst_req
  task automatic run_edges(input int n, output int f_irq, output int f_rst,
                           output int n_irq);
    f_irq = 0; f_rst = 0; n_irq = 0;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin n_irq++; if (f_irq == 0) f_irq = k; end
      if (rst_req && f_rst == 0) f_rst = k;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, fi, fr, ni, base_i, base_r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);
    rd(2'd0, v); chk("R1 pre1", v, 'hFFFFF);
    rd(2'd1, v); chk("R1 pre2", v, 'hFFFFF);
    rd(2'd2, v); chk("R1 kick", v, 0);

    // R2 / R3 unlock vectors
    for (int i = 0; i < NSTEP; i++) begin
      wr(STEPS[i][41:40], STEPS[i][39:20]);
      rd(2'd0, v);
      chk($sformatf("R2/R3 step %0d", i), v, int'(STEPS[i][19:0]));
    end
    rd(2'd1, v); chk("R3 pre2 untouched", v, 'hFFFFF);

    // R11 registered read
    rd(2'd0, v);
    reg_addr = 2'd1; #1;
    chk("R11 before edge", int'(reg_rdata), 'h0000A);
    @(posedge clk); @(negedge clk);
    chk("R11 after edge", int'(reg_rdata), 'hFFFFF);

    uwr(2'd0, 20'd3); uwr(2'd1, 20'd2);
    rd(2'd1, v); chk("R2 pre2 write", v, 2);

    // R5 / R6 timing, fast tick
    cfg_fast_tick = 1'b1; cfg_enable = 1'b1;
    run_edges(200, fi, fr, ni);
    chk("R5 irq edge", fi, 3 * FAST);
    chk("R5 irq count", ni, 1);
    chk("R6 rst_req edge", fr, 5 * FAST);

    // R7 sticky flag
    rd(2'd2, v); chk("R7 flag set", v, 'h200);
    cfg_enable = 1'b0;
    @(negedge clk);
    rd(2'd2, v); chk("R7 flag survives disable", v, 'h200);
    wr(2'd2, 20'h200);
    rd(2'd2, v); chk("R7 locked clear ignored", v, 'h200);
    uwr(2'd2, 20'h200);
    rd(2'd2, v); chk("R7 unlocked clear", v, 0);

    // R9 stop and restart
    base_i = irq_hits;
    cfg_enable = 1'b1;
    run_edges(80, fi, fr, ni);
    cfg_enable = 1'b0;
    run_edges(200, fi, fr, ni);
    chk("R9 no irq while stopped", irq_hits - base_i, 0);
    cfg_enable = 1'b1;
    run_edges(100, fi, fr, ni);
    chk("R9 fresh start", fi, 3 * FAST);
    cfg_enable = 1'b0;
    @(negedge clk);

    // R8 reload keeps it from expiring
    base_i = irq_hits; base_r = rst_hits;
    cfg_enable = 1'b1;
    for (int j = 0; j < 6; j++) begin
      repeat (50) @(negedge clk);
      uwr(2'd2, 20'h100);
    end
    chk("R8 no irq with reloads", irq_hits - base_i, 0);
    chk("R8 no rst_req with reloads", rst_hits - base_r, 0);
    run_edges(100, fi, fr, ni);
    chk("R8 restart from pre1", fi, 3 * FAST);
    cfg_enable = 1'b0;
    @(negedge clk);

    // R5 masked interrupt
    base_i = irq_hits; base_r = rst_hits;
    cfg_irq_off = 1'b1; cfg_enable = 1'b1;
    run_edges(170, fi, fr, ni);
    chk("R5 masked irq", irq_hits - base_i, 0);
    chk("R6 rst_req with mask", rst_hits - base_r, 1);
    cfg_enable = 1'b0; cfg_irq_off = 1'b0;
    @(negedge clk);

    // R4 / R10 slow tick with zero preloads
    uwr(2'd0, 20'd0); uwr(2'd1, 20'd0);
    cfg_fast_tick = 1'b0; cfg_enable = 1'b1;
    run_edges(2 * SLOW + 1, fi, fr, ni);
    chk("R4 R10 slow irq edge", fi, SLOW);
    chk("R4 R10 slow rst_req edge", fr, 2 * SLOW);
    cfg_enable = 1'b0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule